// File: doc/BRIEF.md
# Prescaled Periodic Software Interrupt Timer

This block is a free-running countdown timer that periodically raises a software interrupt status flag. Time is measured in prescaled units: a fixed divide-by-256 prescaler counts cycles in which the time-base enable input is high, and each full prescaler wrap moves a 16-bit countdown one step. When the countdown expires it reloads itself from a 16-bit reload register and starts again. The timer never stops. The interrupt-enable input only decides whether an expiry sets the status flag.

Software sets the period by writing the reload register. A write takes effect at once: both the countdown and the prescaler phase restart from the new value. The status flag stays set until software clears it with a write-one strobe. The interrupt output is the status flag gated by the enable. As an example of scale, with a 20 MHz time base a reload value of 9531 gives roughly 122 ms. The reset value of FFFFh gives the longest period, about 838 ms.

Top module: `swi_timer`

## Requirements
- R1: After reset the reload readback is 16'hFFFF, and both the status flag and the interrupt output are 0.
- R2: With reload value N (1 to 65535), an expiry occurs on the N*256-th clock in which `tb_en` is high, counted from reset or from the last reload write. Clocks with `tb_en` low do not advance the timer.
- R3: A reload value of 0 gives a period of 256 time-base enables, the same as a value of 1.
- R4: After an expiry the timer reloads automatically, and each later expiry follows a further full period.
- R5: A reload write restarts the countdown and clears the prescaler phase. A write in the same cycle as a would-be expiry suppresses that expiry.
- R6: While `irq_en` is 0, an expiry does not set the status flag, but the timer keeps counting and reloading.
- R7: The status flag stays set until a cycle with `stat_clr` high. If an expiry with `irq_en` high falls in that same cycle, the flag stays set.
- R8: `irq` is high exactly when the status flag is set and `irq_en` is high.
- R9: `reload_rdata` shows the value of the most recent reload write, starting from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | Time-base clock enable, one count per high cycle |
| irq_en | input | 1 | Interrupt enable bit |
| reload_wr | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload value to write |
| reload_rdata | output | 16 | Current reload register contents |
| stat_clr | input | 1 | Write-one strobe that clears the status flag |
| irq_stat | output | 1 | Interrupt status flag |
| irq | output | 1 | Interrupt output |

## Verification
The hardest situations to reach are those where a single cycle carries two events: an expiry together with a reload write, or an expiry together with a status clear. To get there, the stimulus drives exactly N*256-1 time-base enables, then raises the competing strobe in the same cycle as the final enable. The bench also shows that the prescaler phase was discarded by a restart: it runs part of a unit, rewrites the reload, and expects the expiry only after a full fresh period. Expiries with the enable low are checked by enabling the interrupt afterwards and timing the next expiry from the original phase.

// File: rtl/swi_timer_pkg.sv
package swi_timer_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_DEC  = 2'd1,
    CNT_LOAD = 2'd2,
    CNT_WRAP = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/swi_prescaler.sv
module swi_prescaler #(
  parameter int LOG2_DIV = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tb_en,
  input  logic restart,
  output logic unit_tick
);
  localparam logic [LOG2_DIV-1:0] PHASE_LAST = {LOG2_DIV{1'b1}};

  logic [LOG2_DIV-1:0] phase_q;
  logic [LOG2_DIV-1:0] phase_d;
  logic                phase_ce;

  always_comb begin
    phase_ce  = restart | tb_en;
    phase_d   = phase_q;
    unit_tick = 1'b0;
    if (restart) begin
      phase_d = '0;
    end else if (tb_en) begin
      phase_d   = phase_q + 1'b1;
      unit_tick = (phase_q == PHASE_LAST);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= '0;
    end else if (phase_ce) begin
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/swi_countdown.sv
module swi_countdown
  import swi_timer_pkg::*;
#(
  parameter int             CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             unit_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] reload_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  cnt_op_e          op;
  logic             last_unit;

  assign last_unit = (cnt_q <= ONE);

  always_comb begin
    if (load)                        op = CNT_LOAD;
    else if (unit_tick && last_unit) op = CNT_WRAP;
    else if (unit_tick)              op = CNT_DEC;
    else                             op = CNT_HOLD;
  end

  always_comb begin
    expire = (op == CNT_WRAP);
    unique case (op)
      CNT_LOAD: cnt_d = load_val;
      CNT_WRAP: cnt_d = reload_q;
      CNT_DEC:  cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= RST_VAL;
    end else if (op != CNT_HOLD) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      reload_q <= RST_VAL;
    end else if (load) begin
      reload_q <= load_val;
    end
  end
endmodule

// File: rtl/swi_status.sv
module swi_status (
  input  logic clk,
  input  logic arst_n,
  input  logic set_ev,
  input  logic clr,
  output logic stat
);
  logic stat_d;

  always_comb begin
    if (set_ev)   stat_d = 1'b1;
    else if (clr) stat_d = 1'b0;
    else          stat_d = stat;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stat <= 1'b0;
    end else if (set_ev | clr) begin
      stat <= stat_d;
    end
  end
endmodule

// File: rtl/swi_timer.sv
module swi_timer #(
  parameter int                 CNT_W    = 16,
  parameter int                 LOG2_DIV = 8,
  parameter logic [CNT_W-1:0]   RST_VAL  = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             irq_en,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_wdata,
  output logic [CNT_W-1:0] reload_rdata,
  input  logic             stat_clr,
  output logic             irq_stat,
  output logic             irq
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   arst_n;
  logic                   unit_tick;
  logic                   expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign arst_n = rst_pipe_q[SYNC_STAGES-1];

  swi_prescaler #(.LOG2_DIV(LOG2_DIV)) u_presc (
    .clk       (clk),
    .arst_n    (arst_n),
    .tb_en     (tb_en),
    .restart   (reload_wr),
    .unit_tick (unit_tick)
  );

  swi_countdown #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk       (clk),
    .arst_n    (arst_n),
    .unit_tick (unit_tick),
    .load      (reload_wr),
    .load_val  (reload_wdata),
    .reload_q  (reload_rdata),
    .expire    (expire)
  );

  swi_status u_stat (
    .clk    (clk),
    .arst_n (arst_n),
    .set_ev (expire & irq_en),
    .clr    (stat_clr),
    .stat   (irq_stat)
  );

  assign irq = irq_stat & irq_en;
endmodule

// File: rtl/swi_timer_checker.sv
module swi_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tb_en,
  input logic             irq_en,
  input logic             reload_wr,
  input logic [CNT_W-1:0] reload_wdata,
  input logic [CNT_W-1:0] reload_rdata,
  input logic             stat_clr,
  input logic             irq_stat,
  input logic             irq
);
  assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  assert_irq_needs_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_stat);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat && !stat_clr) |=> irq_stat);

  assert_no_set_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_stat && !irq_en) |=> !irq_stat);

  assert_write_blocks_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_stat && reload_wr) |=> !irq_stat);

  assert_idle_timebase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_stat && !tb_en) |=> !irq_stat);

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (reload_rdata == $past(reload_wdata)));
endmodule

bind swi_timer swi_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tb_en        (tb_en),
  .irq_en       (irq_en),
  .reload_wr    (reload_wr),
  .reload_wdata (reload_wdata),
  .reload_rdata (reload_rdata),
  .stat_clr     (stat_clr),
  .irq_stat     (irq_stat),
  .irq          (irq)
);

// File: tb/swi_timer_bench.sv
module swi_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        tb_en;
  logic        irq_en;
  logic        reload_wr;
  logic [15:0] reload_wdata;
  logic [15:0] reload_rdata;
  logic        stat_clr;
  logic        irq_stat;
  logic        irq;

  int n_chk;
  int n_bad;

  localparam int NV = 6;
  localparam logic [15:0] V_RLD [NV] = '{16'd1, 16'd2, 16'd3, 16'd0, 16'd5, 16'd2};
  localparam logic        V_EN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam int          V_PER [NV] = '{256, 512, 768, 256, 1280, 512};

  swi_timer u_swi_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tb_en        (tb_en),
    .irq_en       (irq_en),
    .reload_wr    (reload_wr),
    .reload_wdata (reload_wdata),
    .reload_rdata (reload_rdata),
    .stat_clr     (stat_clr),
    .irq_stat     (irq_stat),
    .irq          (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulses(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      tb_en = 1'b1;
      @(negedge clk);
      tb_en = 1'b0;
      if (gaps) @(negedge clk);
    end
  endtask

  task automatic wr_reload(input logic [15:0] v);
    reload_wr = 1'b1;
    reload_wdata = v;
    @(negedge clk);
    reload_wr = 1'b0;
  endtask

  task automatic clear_stat();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; tb_en = 1'b0; irq_en = 1'b0; reload_wr = 1'b0;
    reload_wdata = '0; stat_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 reload", reload_rdata, 16'hFFFF);
    check("R1 stat", {15'd0, irq_stat}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    irq_en = 1'b1;
    pulses(1000, 1'b0);
    check("R1 long period", {15'd0, irq_stat}, 16'd0);

    // table of periods, R2 R3 R6
    for (int v = 0; v < NV; v++) begin
      irq_en = V_EN[v];
      wr_reload(V_RLD[v]);
      clear_stat();
      check("R9 readback", reload_rdata, V_RLD[v]);
      pulses(V_PER[v] - 1, 1'b0);
      check("R2 R3 before expiry", {15'd0, irq_stat}, 16'd0);
      pulses(1, 1'b0);
      check("R2 R3 R6 at expiry", {15'd0, irq_stat}, {15'd0, V_EN[v]});
      check("R8 irq", {15'd0, irq}, {15'd0, V_EN[v]});
    end

    // R8 gating by enable
    irq_en = 1'b1;
    wr_reload(16'd1);
    clear_stat();
    pulses(256, 1'b0);
    irq_en = 1'b0;
    @(negedge clk);
    check("R8 gated irq", {15'd0, irq}, 16'd0);
    check("R7 stat kept", {15'd0, irq_stat}, 16'd1);
    irq_en = 1'b1;
    @(negedge clk);
    check("R8 irq back", {15'd0, irq}, 16'd1);

    // R4 auto reload
    clear_stat();
    check("R7 cleared", {15'd0, irq_stat}, 16'd0);
    pulses(255, 1'b0);
    check("R4 second early", {15'd0, irq_stat}, 16'd0);
    pulses(1, 1'b0);
    check("R4 second expiry", {15'd0, irq_stat}, 16'd1);

    // R7 set beats clear
    pulses(255, 1'b0);
    tb_en = 1'b1; stat_clr = 1'b1;
    @(negedge clk);
    tb_en = 1'b0; stat_clr = 1'b0;
    check("R7 set wins", {15'd0, irq_stat}, 16'd1);

    // R2 gaps in time base
    wr_reload(16'd1);
    clear_stat();
    pulses(255, 1'b1);
    check("R2 gaps early", {15'd0, irq_stat}, 16'd0);
    pulses(1, 1'b1);
    check("R2 gaps expiry", {15'd0, irq_stat}, 16'd1);

    // R5 restart clears prescaler phase
    wr_reload(16'd1);
    clear_stat();
    pulses(100, 1'b0);
    wr_reload(16'd1);
    pulses(255, 1'b0);
    check("R5 phase cleared", {15'd0, irq_stat}, 16'd0);
    pulses(1, 1'b0);
    check("R5 fresh period", {15'd0, irq_stat}, 16'd1);

    // R5 write in expiry cycle
    clear_stat();
    pulses(255, 1'b0);
    tb_en = 1'b1; reload_wr = 1'b1; reload_wdata = 16'd1;
    @(negedge clk);
    tb_en = 1'b0; reload_wr = 1'b0;
    check("R5 expiry suppressed", {15'd0, irq_stat}, 16'd0);
    pulses(255, 1'b0);
    check("R5 after write early", {15'd0, irq_stat}, 16'd0);
    pulses(1, 1'b0);
    check("R5 after write expiry", {15'd0, irq_stat}, 16'd1);

    // R6 keeps running with enable off
    irq_en = 1'b0;
    wr_reload(16'd2);
    clear_stat();
    pulses(512, 1'b0);
    check("R6 no set", {15'd0, irq_stat}, 16'd0);
    irq_en = 1'b1;
    pulses(511, 1'b0);
    check("R6 phase kept early", {15'd0, irq_stat}, 16'd0);
    pulses(1, 1'b0);
    check("R6 phase kept expiry", {15'd0, irq_stat}, 16'd1);

    summary();
  end
endmodule